// File: doc/BRIEF.md
# Multi-Mode Timer with Pulse-Width Capture

This block is an 8-bit up-counter with a preload register and a control register. The control register selects one of three operating modes.

- **Event mode** counts one chosen edge of a synchronized external pin.
- **Timer mode** counts single-cycle enable ticks from one of two internal sources.
- **Pulse-width mode** measures a single pulse on the external pin and then stops by itself.

In every mode, a count step taken from FFh reloads the counter from the preload register and sets a sticky interrupt flag. The flag stays set until the clear input is asserted.

Software programs the block through a small register port. This port selects the control register, the preload register or the live counter, and reads return data combinationally.

In pulse-width mode, a small state machine moves through three states: `PW_ARMED`, `PW_MEASURE` and `PW_HELD`.

| Transition | From | To | Condition |
|---|---|---|---|
| start | `PW_ARMED` | `PW_MEASURE` | The starting edge arrives while the run bit is set in pulse mode. The count step for that cycle is taken. |
| finish | `PW_MEASURE` | `PW_HELD` | The stopping edge arrives. The run bit is cleared by hardware. |
| abort | `PW_MEASURE` | `PW_ARMED` | Software stops the run or leaves pulse mode. |
| rearm | any state | `PW_ARMED` | Any write to the control register. |

While the machine is in `PW_HELD`, the measured value is frozen. Further pin edges are ignored until software sets the run bit again.

Top module: `ptmr_top`

## Requirements
- R1: Register addresses are as follows: 0 selects control, 1 selects preload, 2 selects the counter, and 3 reads as zero. The control fields are bit 3 edge select, bit 4 run, bit 5 source select, and bits 7:6 mode. Bits 2:0 always read as zero.
- R2: Mode 2'b10 (timer) adds one per tick while run is 1. Source select 1 uses `tick_sys_i` and source select 0 uses `tick_alt_i`. The unselected source has no effect.
- R3: Mode 2'b01 (event) adds one per pin edge while run is 1. Edge select 0 counts rising edges and edge select 1 counts falling edges. The counter changes on the third clock edge after the pin changes.
- R4: A count step taken at FFh loads the preload value and sets `irq_o`. This applies in every mode.
- R5: `irq_o` stays set until `irq_clr_i` is asserted. If an overflow and a clear occur in the same cycle, the flag stays set.
- R6: In mode 2'b11 (pulse width) with edge select 1, a rising edge starts the measurement and the next falling edge stops it. With a tick present every cycle, the count grows by exactly the number of cycles the pin was high, and run is then cleared by hardware.
- R7: In pulse-width mode with edge select 0, the roles of the edges are swapped. The block counts low time, and a rising edge seen while armed does not start a measurement.
- R8: After a measurement ends, the counter holds its value through further pulses and ticks. A new measurement starts only after a control write sets run again.
- R9: When run is 0, or the mode is 2'b00, the counter does not change on ticks or pin edges.
- R10: A preload write while run is 0 also loads the counter. While run is 1, the same write leaves the counter unchanged.
- R11: In event and timer modes, run is never cleared by hardware, including on overflow.
- R12: After reset, the control register, the preload register, the counter and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select for both read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| pin_i | input | 1 | External asynchronous input |
| tick_sys_i | input | 1 | System tick enable (source select 1) |
| tick_alt_i | input | 1 | Alternate tick enable (source select 0) |
| irq_clr_i | input | 1 | Clears the overflow flag |
| irq_o | output | 1 | Sticky overflow flag |

## Verification
A pulse-width machine stuck in the wrong state shows up at the ports in one of two ways:

- The run bit is still set on the first control read after the stopping edge.
- The held counter keeps moving during a second pulse, which is visible within one tick.

A wrong edge choice or wrong synchronizer depth shows up as a counter value that is off by one, either on the third clock after a pin change or at the end of a measured pulse. A wrong reload path shows up on the counter read immediately after the step taken from FFh, together with the flag state in that same cycle.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_PULSE = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        PW_ARMED   = 2'b00,
        PW_MEASURE = 2'b01,
        PW_HELD    = 2'b10
    } pw_state_e;

    localparam logic [1:0] REG_CTRL    = 2'd0;
    localparam logic [1:0] REG_PRELOAD = 2'd1;
    localparam logic [1:0] REG_COUNT   = 2'd2;

    localparam int B_EDGE = 3;
    localparam int B_RUN  = 4;
    localparam int B_SRC  = 5;
    localparam int B_MODE = 6;
endpackage

// File: rtl/ptmr_sync_edge.sv
module ptmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign level  = sync_q[STAGES-1];
    assign rise_o = level & ~prev_q;
    assign fall_o = ~level & prev_q;

    // R3
    rise_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/ptmr_pw_fsm.sv
module ptmr_pw_fsm
    import ptmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic start_i,
    input  logic stop_i,
    input  logic rearm_i,
    input  logic run_i,
    output logic count_en_o,
    output logic done_o
);
    pw_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PW_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_ARMED:   if (active_i && start_i) state_d = PW_MEASURE;
            PW_MEASURE: begin
                if (!active_i)   state_d = PW_ARMED;
                else if (stop_i) state_d = PW_HELD;
            end
            PW_HELD:    state_d = PW_HELD;
            default:    state_d = PW_ARMED;
        endcase
        if (rearm_i) state_d = PW_ARMED;
    end

    always_comb begin
        count_en_o = 1'b0;
        done_o     = 1'b0;
        unique case (state_q)
            PW_ARMED:   count_en_o = active_i && start_i;
            PW_MEASURE: begin
                count_en_o = active_i && !stop_i;
                done_o     = active_i && stop_i;
            end
            PW_HELD:    ;
            default:    ;
        endcase
    end

    // R8
    held_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PW_HELD) |-> !run_i);

    // R6
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !rearm_i) |=> !run_i);
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       addr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rdata_o,
    input  logic             pin_i,
    input  logic             tick_sys_i,
    input  logic             tick_alt_i,
    input  logic             irq_clr_i,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             edge_q, run_q, src_q;
    tmode_e           mode_q;
    logic [CNT_W-1:0] preload_q, cnt_q, ctrl_rd;
    logic             irq_q;
    logic             rise, fall, tick, ev_hit, step;
    logic             ctrl_wr, pre_wr, pw_active, pw_start, pw_stop;
    logic             pw_cnt_en, pw_done;

    assign ctrl_wr = wr_en_i && (addr_i == REG_CTRL);
    assign pre_wr  = wr_en_i && (addr_i == REG_PRELOAD);

    ptmr_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .rise_o(rise), .fall_o(fall)
    );

    assign pw_active = run_q && (mode_q == MODE_PULSE);
    assign pw_start  = edge_q ? rise : fall;
    assign pw_stop   = edge_q ? fall : rise;

    ptmr_pw_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .active_i(pw_active),
        .start_i(pw_start), .stop_i(pw_stop), .rearm_i(ctrl_wr),
        .run_i(run_q), .count_en_o(pw_cnt_en), .done_o(pw_done)
    );

    assign tick   = src_q ? tick_sys_i : tick_alt_i;
    assign ev_hit = edge_q ? fall : rise;

    always_comb begin
        unique case (mode_q)
            MODE_EVENT: step = run_q && ev_hit;
            MODE_TIMER: step = run_q && tick;
            MODE_PULSE: step = pw_cnt_en && tick;
            default:    step = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= 1'b0;
            run_q  <= 1'b0;
            src_q  <= 1'b0;
            mode_q <= MODE_OFF;
        end else if (ctrl_wr) begin
            edge_q <= wdata_i[B_EDGE];
            run_q  <= wdata_i[B_RUN];
            src_q  <= wdata_i[B_SRC];
            mode_q <= tmode_e'(wdata_i[B_MODE+1:B_MODE]);
        end else if (pw_done) begin
            run_q  <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preload_q <= '0;
            cnt_q     <= '0;
            irq_q     <= 1'b0;
        end else begin
            if (pre_wr) preload_q <= wdata_i;
            if (pre_wr && !run_q)  cnt_q <= wdata_i;
            else if (step)         cnt_q <= (cnt_q == CNT_MAX) ? preload_q : cnt_q + 1'b1;
            if (step && cnt_q == CNT_MAX) irq_q <= 1'b1;
            else if (irq_clr_i)           irq_q <= 1'b0;
        end
    end

    always_comb begin
        ctrl_rd                     = '0;
        ctrl_rd[B_EDGE]             = edge_q;
        ctrl_rd[B_RUN]              = run_q;
        ctrl_rd[B_SRC]              = src_q;
        ctrl_rd[B_MODE+1:B_MODE]    = mode_q;
        unique case (addr_i)
            REG_CTRL:    rdata_o = ctrl_rd;
            REG_PRELOAD: rdata_o = preload_q;
            REG_COUNT:   rdata_o = cnt_q;
            default:     rdata_o = '0;
        endcase
    end

    assign irq_o = irq_q;

    // R4
    overflow_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q == CNT_MAX && !(pre_wr && !run_q)) |=> (cnt_q == $past(preload_q) && irq_o));

    // R5
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr_i) |=> irq_o);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!run_q || mode_q == MODE_OFF) && !pre_wr) |=> $stable(cnt_q));

    // R11
    run_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && mode_q != MODE_PULSE && !ctrl_wr) |=> run_q);
endmodule

// File: tb/ptmr_top_tb.sv
module ptmr_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       pin = 1'b0, tsys = 1'b0, talt = 1'b0, iclr = 1'b0;
    logic       irq;
    int         n_chk = 0;
    int         n_fail = 0;

    always #4 clk = ~clk;

    ptmr_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin),
        .tick_sys_i(tsys), .tick_alt_i(talt), .irq_clr_i(iclr), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_sys(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tsys = 1'b1;
            @(negedge clk); tsys = 1'b0;
        end
    endtask

    task automatic tick_alt(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); talt = 1'b1;
            @(negedge clk); talt = 1'b0;
        end
    endtask

    task automatic pin_pulse(input logic lvl, input int len);
        @(negedge clk); pin = lvl;
        waitn(len);
        pin = ~lvl;
        waitn(5);
    endtask

    task automatic t_reset;
        rd_chk("R12 ctrl", 2'd0, 8'h00);
        rd_chk("R12 preload", 2'd1, 8'h00);
        rd_chk("R12 count", 2'd2, 8'h00);
        chk("R12 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_layout;
        wr(2'd0, 8'hFF);
        rd_chk("R1 ctrl low bits zero", 2'd0, 8'hF8);
        wr(2'd0, 8'h48);
        rd_chk("R1 ctrl fields", 2'd0, 8'h48);
        wr(2'd0, 8'h00);
        rd_chk("R1 addr3 zero", 2'd3, 8'h00);
    endtask

    task automatic t_preload;
        wr(2'd1, 8'h20);
        rd_chk("R10 stopped load", 2'd2, 8'h20);
        wr(2'd0, 8'hB0);
        wr(2'd1, 8'h55);
        rd_chk("R10 running keeps count", 2'd2, 8'h20);
        rd_chk("R10 preload written", 2'd1, 8'h55);
        wr(2'd0, 8'h80);
    endtask

    task automatic t_timer;
        wr(2'd1, 8'h10);
        wr(2'd0, 8'hB0);
        tick_sys(5);
        rd_chk("R2 sys ticks", 2'd2, 8'h15);
        tick_alt(3);
        rd_chk("R2 alt ignored", 2'd2, 8'h15);
        wr(2'd0, 8'h90);
        tick_alt(3);
        rd_chk("R2 alt ticks", 2'd2, 8'h18);
        tick_sys(2);
        rd_chk("R2 sys ignored", 2'd2, 8'h18);
        wr(2'd0, 8'h80);
    endtask

    task automatic t_idle;
        tick_sys(3);
        rd_chk("R9 run0 timer", 2'd2, 8'h18);
        wr(2'd0, 8'h10);
        tick_sys(2);
        tick_alt(2);
        pin_pulse(1'b1, 4);
        rd_chk("R9 mode00", 2'd2, 8'h18);
        wr(2'd0, 8'h40);
        pin_pulse(1'b1, 4);
        rd_chk("R9 run0 event", 2'd2, 8'h18);
    endtask

    task automatic t_overflow;
        wr(2'd0, 8'h80);
        wr(2'd1, 8'hFD);
        wr(2'd0, 8'hB0);
        tick_sys(2);
        rd_chk("R4 at max", 2'd2, 8'hFF);
        chk("R4 no flag yet", {7'd0, irq}, 8'h00);
        tick_sys(1);
        rd_chk("R4 reload", 2'd2, 8'hFD);
        chk("R4 flag set", {7'd0, irq}, 8'h01);
        rd_chk("R11 run kept", 2'd0, 8'hB0);
        tick_sys(1);
        chk("R5 sticky", {7'd0, irq}, 8'h01);
        @(negedge clk); iclr = 1'b1;
        @(negedge clk); iclr = 1'b0;
        chk("R5 cleared", {7'd0, irq}, 8'h00);
        tick_sys(1);
        @(negedge clk); tsys = 1'b1; iclr = 1'b1;
        @(negedge clk); tsys = 1'b0; iclr = 1'b0;
        chk("R5 set wins", {7'd0, irq}, 8'h01);
        rd_chk("R4 reload again", 2'd2, 8'hFD);
        @(negedge clk); iclr = 1'b1;
        @(negedge clk); iclr = 1'b0;
        wr(2'd0, 8'h80);
    endtask

    task automatic t_event;
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h50);
        @(negedge clk); pin = 1'b1;
        waitn(2);
        rd_chk("R3 before third edge", 2'd2, 8'h00);
        waitn(1);
        rd_chk("R3 third edge", 2'd2, 8'h01);
        waitn(3); pin = 1'b0; waitn(5);
        pin_pulse(1'b1, 4);
        pin_pulse(1'b1, 4);
        rd_chk("R3 rising count", 2'd2, 8'h03);
        wr(2'd0, 8'h58);
        @(negedge clk); pin = 1'b1;
        waitn(4);
        rd_chk("R3 rise ignored", 2'd2, 8'h03);
        pin = 1'b0;
        waitn(4);
        rd_chk("R3 falling count", 2'd2, 8'h04);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_pw_high;
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hF8);
        @(negedge clk); tsys = 1'b1;
        pin_pulse(1'b1, 10);
        rd_chk("R6 high width", 2'd2, 8'h0A);
        rd_chk("R6 run cleared", 2'd0, 8'hE8);
        pin_pulse(1'b1, 6);
        rd_chk("R8 frozen", 2'd2, 8'h0A);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hF8);
        pin_pulse(1'b1, 4);
        rd_chk("R8 rearmed", 2'd2, 8'h04);
        tsys = 1'b0;
    endtask

    task automatic t_pw_low;
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hF0);
        @(negedge clk); tsys = 1'b1;
        pin = 1'b1;
        waitn(5);
        rd_chk("R7 rise no start", 2'd2, 8'h00);
        rd_chk("R7 still armed", 2'd0, 8'hF0);
        pin_pulse(1'b0, 7);
        rd_chk("R7 low width", 2'd2, 8'h07);
        rd_chk("R7 run cleared", 2'd0, 8'hE0);
        pin = 1'b0;
        tsys = 1'b0;
        waitn(5);
    endtask

    task automatic t_pw_ovf;
        wr(2'd1, 8'hFC);
        wr(2'd0, 8'hF8);
        @(negedge clk); tsys = 1'b1;
        pin_pulse(1'b1, 6);
        rd_chk("R4 pulse reload", 2'd2, 8'hFE);
        chk("R4 pulse flag", {7'd0, irq}, 8'h01);
        tsys = 1'b0;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        waitn(3);
        rst_n = 1'b1;
        waitn(1);
        t_reset;
        t_layout;
        t_preload;
        t_timer;
        t_idle;
        t_overflow;
        t_event;
        t_pw_high;
        t_pw_low;
        t_pw_ovf;
        finish_run;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end
endmodule